// File: doc/BRIEF.md
# Password-Protected Watchdog with Prewarning

This block is a watchdog timer built around a 16-bit up-counter. The counter advances on a prescaled tick taken from the system clock, with one of two rates selectable. Software keeps the system alive by servicing the watchdog through a single write port. Each service or configuration change is a two-write sequence. The first write carries a key: a fixed byte plus a software-chosen nibble. The second write carries a guard byte and the new settings. The second write must arrive within a bounded number of ticks after the first.

The block owns an end-of-initialization flag, which it drives out as a chip-wide write-protect line. That flag can only change through a complete, valid sequence. Any of the following counts as a fault: a counter overflow, a wrong key, a wrong guard byte, or an expired unlock window. On a fault the block raises a non-maskable interrupt request. It then waits a fixed prewarning interval and raises its reset request. The block remembers watchdog-caused resets across system resets. On the second one it keeps the reset request asserted until a power-on reset.

The default prescaler divides by 256 or by 16384. In time-out mode the counter reloads to 16'hFF00, which gives 256 ticks before overflow. The prewarning interval is 256 ticks and the unlock window is 4 ticks. All of these values are parameters.

Top module: `wdog_top`

## Requirements
- R1: The counter counts up by one on every tick while counting is enabled. After a reset it starts at the fixed time-out reload value. Overflow past all-ones with counting enabled raises `nmiReq`, one tick after the all-ones value.
- R2: `wrData[10]` in a valid second write selects the tick rate: 0 selects the fast divider (2^FAST_LOG cycles) and 1 selects the slow divider (2^SLOW_LOG cycles). After reset the fast rate is used.
- R3: A valid second write with `wrData[8]`=1 enters normal mode and loads the counter from `wrData[31:16]`. A valid second write with `wrData[8]`=0 enters time-out mode and loads the fixed reload value. The load takes priority over a tick in the same cycle.
- R4: A first write is valid when `wrData[7:0]`=8'h3C and `wrData[11:8]` equals the stored key nibble, which is 0 after reset. A second write is valid when `wrData[7:0]`=8'hC3. A valid second write stores `wrData[15:12]` as the new key nibble.
- R5: A first write with a wrong key, or a second write with a wrong guard byte, raises `nmiReq` on the next cycle.
- R6: If no write follows a valid first write within WIN_TICKS ticks, `nmiReq` is raised.
- R7: A valid second write with `wrData[9]`=1 stops counting, so no overflow occurs. Key and guard checking stay active while counting is stopped.
- R8: After `nmiReq` rises, `rstReq` rises PRE_TICKS ticks later.
- R9: `endInitOut` follows `wrData[8]` of a valid second write and changes by no other write. Any reset clears it.
- R10: The first watchdog reset request clears on `sysRstN`. A second one, with no power-on reset in between, stays asserted through `sysRstN` until `porRstN`.
- R11: After `porRstN` or `sysRstN` is released: `nmiReq`=0, `rstReq`=0 (unless the lock of R10 is set), `endInitOut`=0, and `cntVal` equals the fixed reload value.
- R12: Once `nmiReq` is raised, writes are ignored: `endInitOut` does not change and the reset request still follows on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porRstN | input | 1 | Power-on reset, active low, clears all state |
| sysRstN | input | 1 | System reset, active low, keeps reset history |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrData | input | 32 | Write data: key, guard and settings fields |
| endInitOut | output | 1 | End-of-initialization write-protect line |
| nmiReq | output | 1 | Non-maskable interrupt request (prewarning) |
| rstReq | output | 1 | System reset request |
| cntVal | output | CNT_W | Current counter value |

## Verification
A fault in the key checking or the unlock window tracking shows up on `nmiReq` one cycle after the offending write, or within a few ticks after it. A wrong counter load or a wrong tick rate shows up at once on `cntVal`. A wrong overflow point shows up when `nmiReq` rises too early or too late. A mode register that does not hold after a fault shows up when `endInitOut` changes during prewarning. Broken reset history shows up only after a second fault sequence, as `rstReq` that either drops on `sysRstN` or fails to.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int DATA_W = 32;
  localparam logic [7:0] KEY_FIXED = 8'h3C;
  localparam logic [7:0] GUARD_VAL = 8'hC3;
  localparam int KEY_W = 4;
  localparam int KEY_CHK_LSB = 8;
  localparam int END_BIT = 8;
  localparam int DIS_BIT = 9;
  localparam int SLOW_BIT = 10;
  localparam int KEY_NEW_LSB = 12;
  localparam int RELOAD_LSB = 16;

  typedef enum logic [1:0] {
    MODE_TIMEOUT = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_PREWARN = 2'd2,
    MODE_HALT    = 2'd3
  } wdMode_e;

  typedef struct packed {
    logic loadUser;
    logic loadFix;
    logic loadPre;
    logic winStart;
    logic winClear;
  } wdStrobe_t;

endpackage

// File: rtl/wdog_dpath.sv
module wdog_dpath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FAST_LOG = 8,
  parameter int SLOW_LOG = 14,
  parameter logic [CNT_W-1:0] FIX_RELOAD = 16'hFF00,
  parameter int PRE_TICKS = 256,
  parameter int WIN_TICKS = 4
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             slowSel,
  input  logic             cntEn,
  input  wdStrobe_t        strb,
  input  logic [CNT_W-1:0] reloadIn,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             winActive,
  output logic             winExpire
);

  localparam logic [CNT_W-1:0] PRE_RELOAD = {CNT_W{1'b0}} - CNT_W'(PRE_TICKS);
  localparam int WIN_W = $clog2(WIN_TICKS + 1);
  localparam logic [WIN_W-1:0] WIN_INIT = WIN_W'(WIN_TICKS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(1);

  logic [SLOW_LOG-1:0] preCnt;
  logic [WIN_W-1:0] winCnt;
  logic tick;
  logic fastTick;
  logic slowTick;

  // prescaler: fast tick on low bits all ones, slow tick on all bits
  generate
    if (FAST_LOG == SLOW_LOG) begin : g_sameRate
      assign fastTick = &preCnt;
    end else begin : g_twoRate
      assign fastTick = &preCnt[FAST_LOG-1:0];
    end
  endgenerate
  assign slowTick = &preCnt;
  assign tick = slowSel ? slowTick : fastTick;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      preCnt <= '0;
    end else if (!sysRstN) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // watchdog counter
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cnt <= FIX_RELOAD;
    end else if (!sysRstN) begin
      cnt <= FIX_RELOAD;
    end else if (strb.loadPre) begin
      cnt <= PRE_RELOAD;
    end else if (strb.loadUser) begin
      cnt <= reloadIn;
    end else if (strb.loadFix) begin
      cnt <= FIX_RELOAD;
    end else if (tick && cntEn) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ovf = tick && cntEn && (&cnt);

  // unlock window
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      winActive <= 1'b0;
      winCnt <= '0;
    end else if (!sysRstN) begin
      winActive <= 1'b0;
      winCnt <= '0;
    end else if (strb.winClear) begin
      winActive <= 1'b0;
    end else if (strb.winStart) begin
      winActive <= 1'b1;
      winCnt <= WIN_INIT;
    end else if (tick && winActive) begin
      if (winCnt == WIN_LAST) begin
        winActive <= 1'b0;
      end
      winCnt <= winCnt - 1'b1;
    end
  end

  assign winExpire = tick && winActive && (winCnt == WIN_LAST);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ovf,
  input  logic              winActive,
  input  logic              winExpire,
  output wdStrobe_t         strb,
  output logic              cntEn,
  output logic              slowSel,
  output logic              endInit,
  output logic              nmiReq,
  output logic              rstReq,
  output logic              lockFlag
);

  wdMode_e mode;
  logic disabled;
  logic [KEY_W-1:0] userKey;
  logic firstFlag;

  logic active;
  logic keyMatch;
  logic guardMatch;
  logic firstOk;
  logic firstBad;
  logic secOk;
  logic secBad;
  logic winErr;
  logic ovfErr;
  logic errEvt;
  logic preDone;
  logic newEnd;

  always_comb begin
    active = (mode == MODE_TIMEOUT) || (mode == MODE_NORMAL);
    keyMatch = (wrData[7:0] == KEY_FIXED) &&
               (wrData[KEY_CHK_LSB +: KEY_W] == userKey);
    guardMatch = (wrData[7:0] == GUARD_VAL);
    firstOk = active && wrEn && !winActive && keyMatch;
    firstBad = active && wrEn && !winActive && !keyMatch;
    secOk = active && wrEn && winActive && guardMatch;
    secBad = active && wrEn && winActive && !guardMatch;
    winErr = active && winExpire && !wrEn;
    ovfErr = active && ovf && !secOk;
    errEvt = firstBad || secBad || winErr || ovfErr;
    preDone = (mode == MODE_PREWARN) && ovf;
    newEnd = wrData[END_BIT];
    cntEn = (mode == MODE_PREWARN) || (active && !disabled);

    strb.loadPre = errEvt;
    strb.loadUser = secOk && newEnd;
    strb.loadFix = secOk && !newEnd;
    strb.winStart = firstOk;
    strb.winClear = errEvt || secOk;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      mode <= MODE_TIMEOUT;
      endInit <= 1'b0;
      disabled <= 1'b0;
      slowSel <= 1'b0;
      userKey <= '0;
      nmiReq <= 1'b0;
      rstReq <= 1'b0;
      firstFlag <= 1'b0;
      lockFlag <= 1'b0;
    end else if (!sysRstN) begin
      mode <= MODE_TIMEOUT;
      endInit <= 1'b0;
      disabled <= 1'b0;
      slowSel <= 1'b0;
      userKey <= '0;
      nmiReq <= 1'b0;
      rstReq <= lockFlag;
    end else begin
      if (errEvt) begin
        mode <= MODE_PREWARN;
        nmiReq <= 1'b1;
      end else if (secOk) begin
        endInit <= newEnd;
        disabled <= wrData[DIS_BIT];
        slowSel <= wrData[SLOW_BIT];
        userKey <= wrData[KEY_NEW_LSB +: KEY_W];
        mode <= newEnd ? MODE_NORMAL : MODE_TIMEOUT;
      end
      if (preDone) begin
        mode <= MODE_HALT;
        rstReq <= 1'b1;
        firstFlag <= 1'b1;
        if (firstFlag) begin
          lockFlag <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FAST_LOG = 8,
  parameter int SLOW_LOG = 14,
  parameter logic [CNT_W-1:0] FIX_RELOAD = 16'hFF00,
  parameter int PRE_TICKS = 256,
  parameter int WIN_TICKS = 4
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              endInitOut,
  output logic              nmiReq,
  output logic              rstReq,
  output logic [CNT_W-1:0]  cntVal
);

  wdStrobe_t strb;
  logic cntEn;
  logic slowSel;
  logic ovf;
  logic winActive;
  logic winExpire;
  logic lockFlag;

  wdog_ctrl i_ctrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .sysRstN   (sysRstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .ovf       (ovf),
    .winActive (winActive),
    .winExpire (winExpire),
    .strb      (strb),
    .cntEn     (cntEn),
    .slowSel   (slowSel),
    .endInit   (endInitOut),
    .nmiReq    (nmiReq),
    .rstReq    (rstReq),
    .lockFlag  (lockFlag)
  );

  wdog_dpath #(
    .CNT_W      (CNT_W),
    .FAST_LOG   (FAST_LOG),
    .SLOW_LOG   (SLOW_LOG),
    .FIX_RELOAD (FIX_RELOAD),
    .PRE_TICKS  (PRE_TICKS),
    .WIN_TICKS  (WIN_TICKS)
  ) i_dpath (
    .clk       (clk),
    .porRstN   (porRstN),
    .sysRstN   (sysRstN),
    .slowSel   (slowSel),
    .cntEn     (cntEn),
    .strb      (strb),
    .reloadIn  (wrData[RELOAD_LSB +: CNT_W]),
    .cnt       (cntVal),
    .ovf       (ovf),
    .winActive (winActive),
    .winExpire (winExpire)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
(
  input logic      clk,
  input logic      porRstN,
  input logic      sysRstN,
  input logic      wrEn,
  input logic      endInitOut,
  input logic      nmiReq,
  input logic      rstReq,
  input logic      lockFlag,
  input wdStrobe_t strb
);

  // R8
  rst_after_nmi_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(rstReq) |-> nmiReq);

  // R9
  endinit_by_write_chk: assert property (@(posedge clk) disable iff (!porRstN)
    ($past(sysRstN) && (endInitOut != $past(endInitOut))) |-> $past(wrEn));

  // R12
  nmi_held_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(nmiReq) |-> !$past(sysRstN));

  // R10
  lock_holds_rst_chk: assert property (@(posedge clk) disable iff (!porRstN)
    lockFlag |=> rstReq);

  // R3
  single_load_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strb.loadUser, strb.loadFix, strb.loadPre}));

endmodule

bind wdog_top wdog_chk u_wdogChk (
  .clk        (clk),
  .porRstN    (porRstN),
  .sysRstN    (sysRstN),
  .wrEn       (wrEn),
  .endInitOut (endInitOut),
  .nmiReq     (nmiReq),
  .rstReq     (rstReq),
  .lockFlag   (lockFlag),
  .strb       (strb)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] FIXV = 16'hFFF0;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic sysRstN = 1'b1;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic endInitOut;
  logic nmiReq;
  logic rstReq;
  logic [15:0] cntVal;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_top #(
    .CNT_W(16), .FAST_LOG(2), .SLOW_LOG(4), .FIX_RELOAD(FIXV),
    .PRE_TICKS(8), .WIN_TICKS(4)
  ) i_wdog_top (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .wrEn(wrEn),
    .wrData(wrData), .endInitOut(endInitOut), .nmiReq(nmiReq),
    .rstReq(rstReq), .cntVal(cntVal)
  );

  typedef struct packed {
    logic [31:0] w1;
    logic [31:0] w2;
    logic two;
    logic expNmi;
    logic expEnd;
    logic [3:0] tag;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0000_003C, 32'hFFF0_01C3, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 good pair
    '{32'h0000_003D, 32'h0,         1'b0, 1'b1, 1'b0, 4'd5},  // R5 bad fixed key
    '{32'h0000_013C, 32'h0,         1'b0, 1'b1, 1'b0, 4'd5},  // R5 bad key nibble
    '{32'h0000_003C, 32'h0000_01C2, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 bad guard
    '{32'h0000_003C, 32'h0000_02C3, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 disable pair
    '{32'h0000_01C3, 32'h0,         1'b0, 1'b1, 1'b0, 4'd9},  // R9 no unlock
    '{32'h0000_003C, 32'h0000_51C3, 1'b1, 1'b0, 1'b1, 4'd4}   // R4 new key
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic porPulse();
    porRstN = 1'b0;
    cyc(2);
    porRstN = 1'b1;
  endtask

  task automatic sysPulse();
    sysRstN = 1'b0;
    cyc(2);
    sysRstN = 1'b1;
  endtask

  task automatic waitRst(input int maxC);
    for (int i = 0; i < maxC && !rstReq; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    porPulse();
    // R11 reset state
    chk(nmiReq == 0, "R11 nmi", 32'(nmiReq), 0);
    chk(rstReq == 0, "R11 rst", 32'(rstReq), 0);
    chk(endInitOut == 0, "R11 endInit", 32'(endInitOut), 0);
    chk(cntVal == FIXV, "R11 cnt", 32'(cntVal), 32'(FIXV));

    // table of access sequences
    for (int v = 0; v < 7; v++) begin
      sysPulse();
      doWrite(VECS[v].w1);
      if (VECS[v].two) doWrite(VECS[v].w2);
      cyc(1);
      chk(nmiReq == VECS[v].expNmi, $sformatf("R%0d vec%0d nmi", VECS[v].tag, v),
          32'(nmiReq), 32'(VECS[v].expNmi));
      chk(endInitOut == VECS[v].expEnd, $sformatf("R%0d vec%0d endInit", VECS[v].tag, v),
          32'(endInitOut), 32'(VECS[v].expEnd));
    end
    // R4 key nibble 5 now stored: unlock with key 5 then guard
    doWrite(32'h0000_053C);
    doWrite(32'h0000_00C3);
    cyc(1);
    chk(nmiReq == 0, "R4 stored key accepted", 32'(nmiReq), 0);
    chk(endInitOut == 0, "R9 endInit cleared by pair", 32'(endInitOut), 0);

    // R11 system reset state
    sysPulse();
    chk(cntVal == FIXV && endInitOut == 0 && nmiReq == 0, "R11 sys reset",
        32'(cntVal), 32'(FIXV));

    // R1 timeout overflow, then R8 prewarning
    porPulse();
    cyc(56);
    chk(nmiReq == 0, "R1 no early overflow", 32'(nmiReq), 0);
    cyc(16);
    chk(nmiReq == 1, "R1 overflow nmi", 32'(nmiReq), 1);
    cyc(16);
    chk(rstReq == 0, "R8 no early reset", 32'(rstReq), 0);
    cyc(16);
    chk(rstReq == 1, "R8 reset after prewarn", 32'(rstReq), 1);

    // R3 normal reload, load wins, then counts up
    porPulse();
    doWrite(32'h0000_003C);
    doWrite(32'h1234_01C3);
    chk(cntVal == 16'h1234, "R3 user reload", 32'(cntVal), 32'h1234);
    chk(endInitOut == 1, "R9 endInit set", 32'(endInitOut), 1);
    cyc(8);
    chk(cntVal == 16'h1236, "R1 up count", 32'(cntVal), 32'h1236);

    // R2 slow rate
    porPulse();
    doWrite(32'h0000_003C);
    doWrite(32'hFFF0_05C3);
    cyc(230);
    chk(nmiReq == 0, "R2 slow rate no early nmi", 32'(nmiReq), 0);
    cyc(50);
    chk(nmiReq == 1, "R2 slow rate overflow", 32'(nmiReq), 1);

    // R6 unlock window expiry
    porPulse();
    doWrite(32'h0000_003C);
    cyc(10);
    chk(nmiReq == 0, "R6 window still open", 32'(nmiReq), 0);
    cyc(14);
    chk(nmiReq == 1, "R6 window expired", 32'(nmiReq), 1);

    // R7 disabled counting, access check active
    porPulse();
    doWrite(32'h0000_003C);
    doWrite(32'h0000_02C3);
    cyc(200);
    chk(nmiReq == 0, "R7 disabled no overflow", 32'(nmiReq), 0);
    doWrite(32'h0000_0099);
    cyc(1);
    chk(nmiReq == 1, "R7 access error while disabled", 32'(nmiReq), 1);

    // R12 writes ignored during prewarning
    porPulse();
    doWrite(32'h0000_0011);
    doWrite(32'h0000_003C);
    doWrite(32'h0000_01C3);
    cyc(2);
    chk(endInitOut == 0, "R12 endInit frozen", 32'(endInitOut), 0);
    chk(nmiReq == 1, "R12 nmi held", 32'(nmiReq), 1);
    cyc(40);
    chk(rstReq == 1, "R12 reset still follows", 32'(rstReq), 1);

    // R10 second watchdog reset locks
    porPulse();
    doWrite(32'h0000_0011);
    waitRst(80);
    chk(rstReq == 1, "R10 first reset request", 32'(rstReq), 1);
    sysPulse();
    chk(rstReq == 0, "R10 first reset released", 32'(rstReq), 0);
    doWrite(32'h0000_0011);
    waitRst(80);
    sysPulse();
    cyc(50);
    chk(rstReq == 1, "R10 locked through sys reset", 32'(rstReq), 1);
    porPulse();
    chk(rstReq == 0, "R10 power-on clears lock", 32'(rstReq), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule